// File: doc/BRIEF.md
# Serial Converter Command Port

This block is the digital side of a multi-channel successive-approximation converter's serial port. A host drives an active-low select, a serial clock and a serial data line. The block looks for a start bit, gathers an 8-bit command, and then returns a 12-bit conversion result one bit per serial clock. The analog converter is not modelled: a 12-bit sample word arrives on a parallel port. The block grabs that word when the conversion starts.

Framing has no byte alignment. Zeros are skipped until the first 1 arrives. That 1 opens a command. The block decodes the channel, polarity, input-mode and power/clock-mode fields from the command and holds them on outputs for the rest of the chip. The result shift uses the timing of the externally clocked mode: a one-period strobe, then ten data bits and two sub-LSB bits. A new command may overlap the tail of a result, which gives back-to-back conversions every 15 serial clocks. A start bit that comes too early abandons the conversion in progress.

All pins are sampled with one fast system clock, at least four times the serial clock. Select, serial clock and serial data pass through a synchronizer, and their edges are detected in the system clock domain.

Top module: `sadc_port`

## Requirements
- R1: Synchronous active-high reset clears both output enables, the strobe, serial out and all decoded field outputs to 0.
- R2: While no command is in progress and select is low, bits sampled at serial clock rising edges are ignored while they are 0. The first 1 is the start bit and is the MSB of an 8-bit command.
- R3: After the start bit, the next seven bits are decoded as follows. The first three give the channel (`chan_sel`, MSB first). The next bit is `unipolar`, the next is `single_ended`, and the last two give `pwr_mode` (MSB first).
- R4: On the serial clock falling edge after the eighth command bit, `rdy` rises for exactly one serial clock period, and `ser_out` is 0 while it is high.
- R5: On the next 12 falling edges, `ser_out` presents `sample[11]` down to `sample[0]`, one bit per edge.
- R6: The sample word is captured at the conversion-start falling edge. Later changes on `sample` do not affect the bits shifted out.
- R7: After the twelfth result bit, `ser_out` stays 0 until a new conversion supplies data.
- R8: With the outputs enabled, `ser_out` and `rdy` change only in response to a serial clock falling edge, never while the serial clock is high.
- R9: Select high drops both output enables and forces `ser_out` and `rdy` to 0. Any command or conversion in progress is discarded. After select falls, the enables return high with `ser_out` and `rdy` low.
- R10: A select falling edge on its own never starts a conversion, and serial clocks with select high have no effect.
- R11: A start bit that arrives once the 7th result bit (B3) has been shifted out is taken as the next command. The running result keeps shifting, so a new conversion can begin every 15 serial clocks.
- R12: A start bit that arrives before the 7th result bit has been shifted out abandons the running conversion. `ser_out` is 0 from then on until the new conversion starts.
- R13: The decoded field outputs change only together with the start of a conversion (the rise of `rdy`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low select |
| ser_clk | input | 1 | Serial clock from the host |
| ser_in | input | 1 | Serial command data, sampled on serial clock rise |
| sample | input | 12 | Converter result word standing in for the analog core |
| ser_out | output | 1 | Serial result data |
| ser_out_en | output | 1 | Output enable for ser_out (tri-state control) |
| rdy | output | 1 | Conversion strobe |
| rdy_en | output | 1 | Output enable for rdy (tri-state control) |
| chan_sel | output | 3 | Decoded channel number |
| unipolar | output | 1 | Decoded polarity field, 1 = unipolar |
| single_ended | output | 1 | Decoded input mode, 1 = single-ended |
| pwr_mode | output | 2 | Decoded power/clock mode field |

## Verification
The assertions assume each serial clock phase lasts at least five system clocks. With that margin, a registered output change caused by a falling edge always lands while the raw serial clock is still low. They also assume select changes only while the serial clock is low. The stimulus holds each phase for six system clocks, changes serial data and select only in the low phase, and changes the sample word only between serial clock periods. A behavioural model built on a result queue predicts every output at the end of each low phase. The stimulus pushes the overlap rule to its edges: start bits after six and after seven result bits, a select pulse in the middle of a result, and clocking with select high.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  localparam int CTRL_W = 8;

  typedef struct packed {
    logic [2:0] chan;
    logic       uni;
    logic       sgl;
    logic [1:0] pd;
  } ctrl_t;

  // Field positions within the seven bits that follow the start bit.
  function automatic ctrl_t decode_ctrl(input logic [CTRL_W-2:0] b);
    ctrl_t c;
    c.chan = b[6:4];
    c.uni  = b[3];
    c.sgl  = b[2];
    c.pd   = b[1:0];
    return c;
  endfunction

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sadc_frame.sv
module sadc_frame
  import sadc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              rise,
  input  logic              fall,
  input  logic              bit_in,
  output logic              start_now,
  output logic              pending,
  output logic [CTRL_W-2:0] fields
);

  localparam int             CNT_W = $clog2(CTRL_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CTRL_W - 2);

  logic              active;
  logic [CNT_W-1:0]  cnt;
  logic [CTRL_W-2:0] sr;

  // A 1 seen while no command is being gathered opens a new command.
  assign start_now = en & rise & ~active & ~pending & bit_in;
  assign fields    = sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else if (en && rise && active) begin
      sr <= {sr[CTRL_W-3:0], bit_in};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      active  <= 1'b0;
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      if (start_now) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (rise && active) begin
        if (cnt == LAST) begin
          active  <= 1'b0;
          pending <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (fall && pending) pending <= 1'b0;
    end
  end

endmodule

// File: rtl/sadc_shift.sv
module sadc_shift #(
  parameter int DATA_W = 10,
  parameter int SUB_W  = 2,
  localparam int RES_W = DATA_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             fall,
  input  logic             pending,
  input  logic             start_now,
  input  logic [RES_W-1:0] sample,
  output logic             ser_out,
  output logic             rdy
);

  localparam int               CNT_W  = $clog2(RES_W + 1);
  // Output position (1-based) of data bit 3: new starts are safe from here on.
  localparam logic [CNT_W-1:0] B3_POS = CNT_W'(DATA_W - 3);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(RES_W - 1);

  logic             conv;
  logic [CNT_W-1:0] out_cnt;
  logic [RES_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      conv    <= 1'b0;
      out_cnt <= '0;
      ser_out <= 1'b0;
      rdy     <= 1'b0;
      if (rst) sh <= '0;
    end else begin
      if (start_now && conv && out_cnt < B3_POS) conv <= 1'b0;
      if (fall) begin
        if (pending) begin
          rdy     <= 1'b1;
          ser_out <= 1'b0;
          sh      <= sample;
          conv    <= 1'b1;
          out_cnt <= '0;
        end else if (conv) begin
          rdy     <= 1'b0;
          ser_out <= sh[RES_W-1];
          sh      <= {sh[RES_W-2:0], 1'b0};
          out_cnt <= out_cnt + 1'b1;
          if (out_cnt == LAST) conv <= 1'b0;
        end else begin
          rdy     <= 1'b0;
          ser_out <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/sadc_port.sv
module sadc_port
  import sadc_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int SUB_W       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int RES_W      = DATA_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n,
  input  logic             ser_clk,
  input  logic             ser_in,
  input  logic [RES_W-1:0] sample,
  output logic             ser_out,
  output logic             ser_out_en,
  output logic             rdy,
  output logic             rdy_en,
  output logic [2:0]       chan_sel,
  output logic             unipolar,
  output logic             single_ended,
  output logic [1:0]       pwr_mode
);

  logic [2:0] pins_s;
  logic       sel_s, clk_s, din_s;
  logic       clk_q, sel_q;
  logic       active, rise, fall;
  logic       start_now, pending;
  logic [CTRL_W-2:0] fields;
  ctrl_t      ctrl_q;
  logic       oe_q;

  sadc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sel_n, ser_clk, ser_in}),
    .q   (pins_s)
  );

  assign {sel_s, clk_s, din_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q <= 1'b0;
      sel_q <= 1'b1;
    end else begin
      clk_q <= clk_s;
      sel_q <= sel_s;
    end
  end

  assign active = ~sel_s;
  assign rise   = clk_s & ~clk_q;
  assign fall   = ~clk_s & clk_q;

  sadc_frame u_frame (
    .clk       (clk),
    .rst       (rst),
    .en        (active),
    .rise      (rise),
    .fall      (fall),
    .bit_in    (din_s),
    .start_now (start_now),
    .pending   (pending),
    .fields    (fields)
  );

  sadc_shift #(.DATA_W(DATA_W), .SUB_W(SUB_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .en        (active),
    .fall      (fall),
    .pending   (pending),
    .start_now (start_now),
    .sample    (sample),
    .ser_out   (ser_out),
    .rdy       (rdy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= active;
      if (active && fall && pending) ctrl_q <= decode_ctrl(fields);
    end
  end

  assign ser_out_en   = oe_q;
  assign rdy_en       = oe_q;
  assign chan_sel     = ctrl_q.chan;
  assign unipolar     = ctrl_q.uni;
  assign single_ended = ctrl_q.sgl;
  assign pwr_mode     = ctrl_q.pd;

endmodule

// File: rtl/sadc_port_chk.sv
module sadc_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       sel_n,
  input logic       ser_clk,
  input logic       ser_out,
  input logic       ser_out_en,
  input logic       rdy,
  input logic       rdy_en,
  input logic [2:0] chan_sel,
  input logic       unipolar,
  input logic       single_ended,
  input logic [1:0] pwr_mode
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (!ser_out_en && !rdy_en && !rdy && !ser_out && chan_sel == 3'd0
                    && !unipolar && !single_ended && pwr_mode == 2'd0)); // R1

  AST_STRB_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    rdy |-> !ser_out); // R4

  AST_CHANGE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (ser_out_en && $past(ser_out_en) && (!$stable(ser_out) || !$stable(rdy))) |-> !ser_clk); // R8

  AST_HIZ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ser_out_en |-> (!ser_out && !rdy)); // R9

  AST_SEL_HIGH_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (sel_n && $past(sel_n) && $past(sel_n, 2) && $past(sel_n, 3) && $past(sel_n, 4))
      |-> (!ser_out_en && !rdy_en)); // R9

  AST_FIELDS_AT_START: assert property (@(posedge clk) disable iff (rst)
    (!$stable(chan_sel) || !$stable(unipolar) || !$stable(single_ended) || !$stable(pwr_mode))
      |-> $rose(rdy)); // R13

endmodule

bind sadc_port sadc_port_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .sel_n        (sel_n),
  .ser_clk      (ser_clk),
  .ser_out      (ser_out),
  .ser_out_en   (ser_out_en),
  .rdy          (rdy),
  .rdy_en       (rdy_en),
  .chan_sel     (chan_sel),
  .unipolar     (unipolar),
  .single_ended (single_ended),
  .pwr_mode     (pwr_mode)
);

// File: tb/sadc_port_tb.sv
module sadc_port_tb;

  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst;
  logic        sel_n, ser_clk, ser_in;
  logic [11:0] sample;
  logic        ser_out, ser_out_en, rdy, rdy_en;
  logic [2:0]  chan_sel;
  logic        unipolar, single_ended;
  logic [1:0]  pwr_mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural reference state
  bit   m_cap, m_pend, m_conv, m_dout, m_strb, m_oe;
  int   m_cnt, m_byte, m_outn, m_ctrl;
  bit   m_q[$];

  always #4 clk = ~clk;

  sadc_port u_dut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .ser_clk(ser_clk), .ser_in(ser_in),
    .sample(sample), .ser_out(ser_out), .ser_out_en(ser_out_en), .rdy(rdy),
    .rdy_en(rdy_en), .chan_sel(chan_sel), .unipolar(unipolar),
    .single_ended(single_ended), .pwr_mode(pwr_mode)
  );

  task automatic check(input string tag);
    logic [10:0] act, exp;
    act = {ser_out_en, rdy_en, rdy, ser_out, chan_sel, unipolar, single_ended, pwr_mode};
    exp = {m_oe, m_oe, m_strb, m_dout, 7'(m_ctrl)};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_rise(input bit d);
    if (sel_n || m_pend) return;
    if (m_cap) begin
      m_byte = m_byte * 2 + int'(d);
      m_cnt++;
      if (m_cnt == 8) begin m_cap = 0; m_pend = 1; end
    end else if (d) begin
      m_cap = 1; m_cnt = 1; m_byte = 1;
      if (m_conv && m_outn < 7) begin m_conv = 0; m_q.delete(); end
    end
  endtask

  task automatic model_fall();
    if (sel_n) return;
    if (m_pend) begin
      m_pend = 0; m_strb = 1; m_dout = 0; m_q.delete();
      for (int i = 11; i >= 0; i--) m_q.push_back(sample[i]);
      m_conv = 1; m_outn = 0; m_ctrl = m_byte;
    end else if (m_conv) begin
      m_strb = 0; m_dout = m_q.pop_front(); m_outn++;
      if (m_q.size() == 0) m_conv = 0;
    end else begin
      m_strb = 0; m_dout = 0;
    end
  endtask

  task automatic set_sel(input bit v, input string tag);
    @(negedge clk) sel_n = v;
    m_cap = 0; m_pend = 0; m_conv = 0; m_q.delete(); m_dout = 0; m_strb = 0;
    m_oe = !v;
    repeat (H) @(negedge clk);
    check(tag);
  endtask

  task automatic send_bit(input bit d, input string tag);
    @(negedge clk) ser_in = d;
    repeat (H) @(negedge clk);
    ser_clk = 1'b1; model_rise(d);
    repeat (H) @(negedge clk);
    ser_clk = 1'b0; model_fall();
    repeat (H) @(negedge clk);
    check(tag);
  endtask

  task automatic send_byte(input logic [7:0] b, input string tag);
    for (int i = 7; i >= 0; i--) send_bit(b[i], tag);
  endtask

  task automatic zeros(input int n, input string tag);
    for (int i = 0; i < n; i++) send_bit(1'b0, tag);
  endtask

  initial begin
    rst = 1; sel_n = 1; ser_clk = 0; ser_in = 0; sample = '0;
    m_cap = 0; m_pend = 0; m_conv = 0; m_dout = 0; m_strb = 0; m_oe = 0;
    m_cnt = 0; m_byte = 0; m_outn = 0; m_ctrl = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    check("R1");

    set_sel(1'b0, "R9");
    zeros(5, "R2");
    // chan 5, unipolar, differential, mode 3
    sample = 12'hA5C;
    send_byte(8'b1_101_1_0_11, "R2 R3 R4");
    zeros(2, "R5 R8");
    sample = 12'h3F0;
    zeros(11, "R5 R6");
    zeros(4, "R7");

    // back-to-back: start bit right after the 7th result bit
    sample = 12'h6B1;
    send_byte(8'b1_010_0_1_01, "R3 R4");
    zeros(7, "R5");
    sample = 12'hFFF;
    send_byte(8'b1_111_1_1_10, "R11");
    zeros(14, "R11 R13");

    // start bit right after the 6th result bit aborts
    sample = 12'h001;
    send_byte(8'b1_001_0_0_00, "R4");
    zeros(6, "R5");
    sample = 12'hC35;
    send_byte(8'b1_110_1_1_01, "R12");
    zeros(14, "R12");

    // select pulse in the middle of a result
    sample = 12'h9A6;
    send_byte(8'b1_011_0_1_11, "R4");
    zeros(4, "R5");
    set_sel(1'b1, "R9");
    send_bit(1'b1, "R10");
    send_byte(8'b1_100_1_0_00, "R10");
    set_sel(1'b0, "R9 R10");
    zeros(6, "R10");
    sample = 12'h555;
    send_byte(8'b1_000_0_0_10, "R3 R13");
    zeros(14, "R5 R7");
    set_sel(1'b1, "R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule